// File: doc/BRIEF.md
# ATA Programmed-I/O Cycle Sequencer

This block runs a single programmed-I/O transfer on a parallel ATA device bus. When idle, it accepts a host request that names the direction, one of two chip selects, a 3-bit device register address, 16-bit write data and four timing counts in system clocks. It then drives the bus through four phases in order: address setup, strobe active, strobe release with optional write-data hold, and end-of-cycle recovery.

Every phase length is an 8-bit count supplied with the request and latched when the request is accepted, so each transfer can use its own timing. A per-request enable lets the device ready line stretch the strobe. Read data is captured from the device data bus as the strobe is released. A one-clock acknowledge marks that point for both reads and writes.

Top module: `ata_pio_engine`

## Requirements
- R1: While rst_ni is low, and in the first cycle after it is released, busy_o, ack_o and dd_oe_o are 0, cs0_no, cs1_no, dior_no and diow_no are 1, and da_o is 0. An asynchronous reset in the middle of a transfer returns the bus to this state at once.
- R2: A request (req_i high at a clock edge while busy_o is 0) makes busy_o 1 from the next cycle. While busy_o is 1, exactly one chip select is low (cs0_no when req_cs1_i was 0, cs1_no when it was 1) and da_o equals the requested address.
- R3: The strobe (dior_no for reads where req_we_i=0, diow_no for writes where req_we_i=1) first goes low exactly max(T1,1) cycles after the first busy cycle. Only the strobe for the requested direction is ever driven.
- R4: With IORDY checking disabled, the strobe stays low for exactly max(T2,1) cycles, whatever the level of iordy_i.
- R5: With IORDY checking enabled, the strobe stays low for at least max(T2,1) cycles and is released only at the first clock edge, at or after the last of those cycles, where iordy_i is high.
- R6: ack_o is high for exactly one cycle: the first cycle after the strobe is released. On a read, rdata_o then holds the value of dd_i at the edge where the strobe was released, and it keeps that value afterwards.
- R7: On a write, dd_oe_o is 1 and dd_o equals the write data in every strobe cycle and for max(T4,1) cycles after the strobe is released. dd_oe_o is never 1 on a read.
- R8: After the strobe is released, busy_o stays 1 for max(Teoc,1) cycles on a read and max(Teoc,1,T4) cycles on a write. After that, all selects and strobes are inactive.
- R9: A request presented while busy_o is 1 is ignored: the timing, chip select and address of the running transfer do not change, and no second transfer follows.
- R10: A count of 0 in any of T1, T2, T4 or Teoc behaves as a count of 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Start a transfer (taken only when idle) |
| req_we_i | input | 1 | 1 = write, 0 = read |
| req_cs1_i | input | 1 | 1 = second chip select, 0 = first |
| req_addr_i | input | 3 | Device register address |
| req_wdata_i | input | 16 | Write data |
| req_iordy_en_i | input | 1 | Let iordy_i stretch the strobe |
| t1_i | input | 8 | Setup count in clocks |
| t2_i | input | 8 | Strobe width count in clocks |
| t4_i | input | 8 | Write-data hold count in clocks |
| teoc_i | input | 8 | Recovery count in clocks |
| iordy_i | input | 1 | Device ready, high = ready |
| dd_i | input | 16 | Device data bus input |
| busy_o | output | 1 | Transfer in progress |
| ack_o | output | 1 | One-clock pulse after strobe release |
| rdata_o | output | 16 | Captured read data |
| cs0_no | output | 1 | First chip select, active low |
| cs1_no | output | 1 | Second chip select, active low |
| da_o | output | 3 | Device address lines |
| dior_no | output | 1 | Read strobe, active low |
| diow_no | output | 1 | Write strobe, active low |
| dd_o | output | 16 | Device data bus output |
| dd_oe_o | output | 1 | Device data bus driver enable |

## Verification
On a write, the write-data hold and the recovery phase run side by side. They can end in the same cycle, and which one closes the transfer changes the busy length. The bench provokes this with writes where T4 equals Teoc, T4 exceeds Teoc and T4 is below it. For each, it counts the cycles after strobe release that have dd_oe_o high and that have busy_o high, and checks that the busy count equals the larger of the two clamped counts and the enable count equals the clamped T4.

// File: rtl/ata_pio_pkg.sv
package ata_pio_pkg;
  localparam int unsigned DEV_ADDR_W = 3;

  typedef enum logic [1:0] {
    PH_IDLE   = 2'd0,
    PH_SETUP  = 2'd1,
    PH_STROBE = 2'd2,
    PH_RECOV  = 2'd3
  } pio_phase_e;
endpackage

// File: rtl/ata_pio_req_reg.sv
module ata_pio_req_reg
  import ata_pio_pkg::*;
#(
  parameter int unsigned DATA_W = 16,
  parameter int unsigned CNT_W  = 8
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  load_i,
  input  logic                  we_i,
  input  logic                  cs1_i,
  input  logic [DEV_ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0]     wdata_i,
  input  logic                  iordy_en_i,
  input  logic [CNT_W-1:0]      t2_i,
  input  logic [CNT_W-1:0]      t4_i,
  input  logic [CNT_W-1:0]      teoc_i,
  output logic                  we_o,
  output logic                  cs1_o,
  output logic [DEV_ADDR_W-1:0] addr_o,
  output logic [DATA_W-1:0]     wdata_o,
  output logic                  iordy_en_o,
  output logic [CNT_W-1:0]      t2_o,
  output logic [CNT_W-1:0]      t4_o,
  output logic [CNT_W-1:0]      teoc_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      we_o       <= 1'b0;
      cs1_o      <= 1'b0;
      addr_o     <= '0;
      wdata_o    <= '0;
      iordy_en_o <= 1'b0;
      t2_o       <= '0;
      t4_o       <= '0;
      teoc_o     <= '0;
    end else if (load_i) begin
      we_o       <= we_i;
      cs1_o      <= cs1_i;
      addr_o     <= addr_i;
      wdata_o    <= wdata_i;
      iordy_en_o <= iordy_en_i;
      t2_o       <= t2_i;
      t4_o       <= t4_i;
      teoc_o     <= teoc_i;
    end
  end
endmodule

// File: rtl/ata_pio_hold_cnt.sv
module ata_pio_hold_cnt #(
  parameter int unsigned CNT_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [CNT_W-1:0] t4_i,
  output logic             act_o,
  output logic             last_o
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      act_o <= 1'b0;
      cnt_q <= '0;
    end else if (load_i) begin
      act_o <= 1'b1;
      cnt_q <= (t4_i == '0) ? '0 : t4_i - 1'b1;
    end else if (act_o) begin
      if (cnt_q == '0) act_o <= 1'b0;
      else             cnt_q <= cnt_q - 1'b1;
    end
  end

  assign last_o = act_o && (cnt_q == '0);
endmodule

// File: rtl/ata_pio_seq.sv
module ata_pio_seq
  import ata_pio_pkg::*;
#(
  parameter int unsigned CNT_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             req_i,
  input  logic [CNT_W-1:0] t1_i,
  input  logic [CNT_W-1:0] t2_q_i,
  input  logic [CNT_W-1:0] teoc_q_i,
  input  logic             iordy_en_q_i,
  input  logic             iordy_i,
  input  logic             hold_act_i,
  input  logic             hold_last_i,
  output pio_phase_e       phase_o,
  output logic             accept_o,
  output logic             strobe_end_o
);
  logic [CNT_W-1:0] cnt_q;
  logic             cnt_zero;
  logic             ready_ok;

  // count of 0 loads like a count of 1
  function automatic logic [CNT_W-1:0] ld(input logic [CNT_W-1:0] t);
    return (t == '0) ? '0 : t - 1'b1;
  endfunction

  assign cnt_zero     = (cnt_q == '0);
  assign ready_ok     = !iordy_en_q_i || iordy_i;
  assign accept_o     = (phase_o == PH_IDLE) && req_i;
  assign strobe_end_o = (phase_o == PH_STROBE) && cnt_zero && ready_ok;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_o <= PH_IDLE;
      cnt_q   <= '0;
    end else begin
      unique case (phase_o)
        PH_IDLE: if (req_i) begin
          phase_o <= PH_SETUP;
          cnt_q   <= ld(t1_i);
        end
        PH_SETUP: if (cnt_zero) begin
          phase_o <= PH_STROBE;
          cnt_q   <= ld(t2_q_i);
        end else begin
          cnt_q <= cnt_q - 1'b1;
        end
        PH_STROBE: if (!cnt_zero) begin
          cnt_q <= cnt_q - 1'b1;
        end else if (ready_ok) begin
          phase_o <= PH_RECOV;
          cnt_q   <= ld(teoc_q_i);
        end
        PH_RECOV: if (!cnt_zero) begin
          cnt_q <= cnt_q - 1'b1;
        end else if (!hold_act_i || hold_last_i) begin
          phase_o <= PH_IDLE;
        end
        default: phase_o <= PH_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/ata_pio_engine.sv
module ata_pio_engine
  import ata_pio_pkg::*;
#(
  parameter int unsigned DATA_W = 16,
  parameter int unsigned CNT_W  = 8
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  req_i,
  input  logic                  req_we_i,
  input  logic                  req_cs1_i,
  input  logic [DEV_ADDR_W-1:0] req_addr_i,
  input  logic [DATA_W-1:0]     req_wdata_i,
  input  logic                  req_iordy_en_i,
  input  logic [CNT_W-1:0]      t1_i,
  input  logic [CNT_W-1:0]      t2_i,
  input  logic [CNT_W-1:0]      t4_i,
  input  logic [CNT_W-1:0]      teoc_i,
  input  logic                  iordy_i,
  input  logic [DATA_W-1:0]     dd_i,
  output logic                  busy_o,
  output logic                  ack_o,
  output logic [DATA_W-1:0]     rdata_o,
  output logic                  cs0_no,
  output logic                  cs1_no,
  output logic [DEV_ADDR_W-1:0] da_o,
  output logic                  dior_no,
  output logic                  diow_no,
  output logic [DATA_W-1:0]     dd_o,
  output logic                  dd_oe_o
);
  pio_phase_e            phase;
  logic                  accept, strobe_end;
  logic                  hold_act, hold_last;
  logic                  we_q, cs1_q, iordy_en_q;
  logic [DEV_ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0]     wdata_q;
  logic [CNT_W-1:0]      t2_q, t4_q, teoc_q;
  logic                  strobe_on;

  ata_pio_req_reg #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_req (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_i     (accept),
    .we_i       (req_we_i),
    .cs1_i      (req_cs1_i),
    .addr_i     (req_addr_i),
    .wdata_i    (req_wdata_i),
    .iordy_en_i (req_iordy_en_i),
    .t2_i       (t2_i),
    .t4_i       (t4_i),
    .teoc_i     (teoc_i),
    .we_o       (we_q),
    .cs1_o      (cs1_q),
    .addr_o     (addr_q),
    .wdata_o    (wdata_q),
    .iordy_en_o (iordy_en_q),
    .t2_o       (t2_q),
    .t4_o       (t4_q),
    .teoc_o     (teoc_q)
  );

  ata_pio_seq #(.CNT_W(CNT_W)) u_seq (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .req_i        (req_i),
    .t1_i         (t1_i),
    .t2_q_i       (t2_q),
    .teoc_q_i     (teoc_q),
    .iordy_en_q_i (iordy_en_q),
    .iordy_i      (iordy_i),
    .hold_act_i   (hold_act),
    .hold_last_i  (hold_last),
    .phase_o      (phase),
    .accept_o     (accept),
    .strobe_end_o (strobe_end)
  );

  ata_pio_hold_cnt #(.CNT_W(CNT_W)) u_hold (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (strobe_end && we_q),
    .t4_i   (t4_q),
    .act_o  (hold_act),
    .last_o (hold_last)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ack_o   <= 1'b0;
      rdata_o <= '0;
    end else begin
      ack_o <= strobe_end;
      if (strobe_end && !we_q) rdata_o <= dd_i;
    end
  end

  assign busy_o    = (phase != PH_IDLE);
  assign strobe_on = (phase == PH_STROBE);
  assign cs0_no    = !(busy_o && !cs1_q);
  assign cs1_no    = !(busy_o && cs1_q);
  assign da_o      = busy_o ? addr_q : '0;
  assign dior_no   = !(strobe_on && !we_q);
  assign diow_no   = !(strobe_on && we_q);
  assign dd_oe_o   = we_q && (strobe_on || hold_act);
  assign dd_o      = dd_oe_o ? wdata_q : '0;
endmodule

// File: rtl/ata_pio_engine_chk.sv
module ata_pio_engine_chk #(
  parameter int unsigned DATA_W = 16,
  parameter int unsigned AW     = 3
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          busy_o,
  input logic          ack_o,
  input logic          cs0_no,
  input logic          cs1_no,
  input logic [AW-1:0] da_o,
  input logic          dior_no,
  input logic          diow_no,
  input logic          dd_oe_o
);
  AST_ONE_SELECT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(!cs0_no && !cs1_no)); // R2
  AST_STROBE_SELECTED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!dior_no || !diow_no) |-> (busy_o && (!cs0_no || !cs1_no))); // R3
  AST_STROBE_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(!dior_no && !diow_no)); // R3
  AST_ACK_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ack_o |=> !ack_o); // R6
  AST_ACK_AFTER_STROBE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ack_o |-> ($past(!dior_no || !diow_no) && dior_no && diow_no)); // R6
  AST_OE_NOT_ON_READ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dd_oe_o |-> dior_no); // R7
  AST_IDLE_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> (cs0_no && cs1_no && dior_no && diow_no && !dd_oe_o)); // R8
  AST_SEL_STABLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && $past(busy_o)) |-> ($stable(da_o) && $stable(cs0_no) && $stable(cs1_no))); // R9
  AST_NO_INSTANT_STROBE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |=> (dior_no && diow_no)); // R10
endmodule

bind ata_pio_engine ata_pio_engine_chk #(.DATA_W(DATA_W), .AW(ata_pio_pkg::DEV_ADDR_W)) u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .busy_o  (busy_o),
  .ack_o   (ack_o),
  .cs0_no  (cs0_no),
  .cs1_no  (cs1_no),
  .da_o    (da_o),
  .dior_no (dior_no),
  .diow_no (diow_no),
  .dd_oe_o (dd_oe_o)
);

// File: tb/ata_pio_engine_tb_top.sv
`timescale 1ns/1ps
module ata_pio_engine_tb_top;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        req_i = 1'b0, req_we_i = 1'b0, req_cs1_i = 1'b0, req_iordy_en_i = 1'b0;
  logic [2:0]  req_addr_i = '0;
  logic [15:0] req_wdata_i = '0, dd_i = '0;
  logic [7:0]  t1_i = '0, t2_i = '0, t4_i = '0, teoc_i = '0;
  logic        iordy_i = 1'b0;
  logic        busy_o, ack_o, cs0_no, cs1_no, dior_no, diow_no, dd_oe_o;
  logic [15:0] rdata_o, dd_o;
  logic [2:0]  da_o;

  int checks = 0;
  int errors = 0;

  always #2.5 clk_i = ~clk_i;

  ata_pio_engine dut_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .req_i(req_i), .req_we_i(req_we_i),
    .req_cs1_i(req_cs1_i), .req_addr_i(req_addr_i), .req_wdata_i(req_wdata_i),
    .req_iordy_en_i(req_iordy_en_i), .t1_i(t1_i), .t2_i(t2_i), .t4_i(t4_i),
    .teoc_i(teoc_i), .iordy_i(iordy_i), .dd_i(dd_i), .busy_o(busy_o),
    .ack_o(ack_o), .rdata_o(rdata_o), .cs0_no(cs0_no), .cs1_no(cs1_no),
    .da_o(da_o), .dior_no(dior_no), .diow_no(diow_no), .dd_o(dd_o),
    .dd_oe_o(dd_oe_o)
  );

  typedef struct packed {
    bit        we;
    bit        cs1;
    bit [2:0]  addr;
    bit [15:0] wdata;
    bit [7:0]  t1;
    bit [7:0]  t2;
    bit [7:0]  t4;
    bit [7:0]  teoc;
    bit [15:0] rd;
  } vec_t;

  localparam int NV = 6;
  localparam vec_t VECS [NV] = '{
    '{1'b0, 1'b0, 3'd7, 16'h0000, 8'd6, 8'd28, 8'd2, 8'd23, 16'hBEEF},
    '{1'b1, 1'b1, 3'd2, 16'hA55A, 8'd3, 8'd4,  8'd2, 8'd5,  16'h0000},
    '{1'b1, 1'b0, 3'd0, 16'h1E2D, 8'd1, 8'd2,  8'd9, 8'd3,  16'h0000},
    '{1'b0, 1'b1, 3'd5, 16'h0000, 8'd0, 8'd0,  8'd0, 8'd0,  16'h1234},
    '{1'b1, 1'b0, 3'd1, 16'h0F0F, 8'd0, 8'd0,  8'd0, 8'd0,  16'h0000},
    '{1'b1, 1'b1, 3'd6, 16'hC3C3, 8'd2, 8'd3,  8'd4, 8'd4,  16'h0000}
  };

  function automatic int c1(input int t);
    return (t == 0) ? 1 : t;
  endfunction
  function automatic int mx(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

  task automatic chk(input string rq, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", rq, what, act, exp);
    end
  endtask

  task automatic check_idle(input string rq);
    chk(rq, "busy_o", busy_o, 0);
    chk(rq, "ack_o", ack_o, 0);
    chk(rq, "cs0_no,cs1_no", {cs0_no, cs1_no}, 3);
    chk(rq, "dior_no,diow_no", {dior_no, diow_no}, 3);
    chk(rq, "dd_oe_o", dd_oe_o, 0);
    chk(rq, "da_o", da_o, 0);
  endtask

  // en: IORDY checking, rel: strobe cycles before iordy_i rises, poke: request during busy
  task automatic run_req(input vec_t v, input bit en, input int rel, input bit poke, input string tag);
    int setup_n = 0, strobe_n = 0, post_n = 0, oe_post = 0;
    int ack_n = 0, ack_pos = -1, sel_bad = 0, wrong_strobe = 0, oe_bad = 0;
    bit seen = 0;
    bit strb, other;
    int exp_strobe, exp_post;
    @(negedge clk_i);
    req_we_i = v.we; req_cs1_i = v.cs1; req_addr_i = v.addr; req_wdata_i = v.wdata;
    t1_i = v.t1; t2_i = v.t2; t4_i = v.t4; teoc_i = v.teoc; dd_i = v.rd;
    req_iordy_en_i = en;
    iordy_i = (en && rel == 0);
    req_i = 1'b1;
    @(negedge clk_i);
    if (poke) begin
      req_addr_i = ~v.addr; req_cs1_i = ~v.cs1; req_we_i = ~v.we;
      t1_i = 8'd1; t2_i = 8'd1; teoc_i = 8'd1; t4_i = 8'd1;
    end else begin
      req_i = 1'b0;
    end
    chk("R2", {tag, " busy after accept"}, busy_o, 1);
    for (int k = 0; k < 3000; k++) begin
      if (k > 0) @(negedge clk_i);
      strb  = v.we ? !diow_no : !dior_no;
      other = v.we ? !dior_no : !diow_no;
      if (other) wrong_strobe++;
      if (!busy_o) break;
      if (cs0_no != v.cs1 || cs1_no != !v.cs1 || da_o != v.addr) sel_bad++;
      if (strb) begin
        strobe_n++;
        seen = 1;
        if (v.we && !(dd_oe_o && dd_o == v.wdata)) oe_bad++;
        if (!v.we && dd_oe_o) oe_bad++;
        if (en && strobe_n >= rel) iordy_i = 1'b1;
      end else if (!seen) begin
        setup_n++;
      end else begin
        post_n++;
        if (dd_oe_o) begin
          oe_post++;
          if (dd_o != v.wdata) oe_bad++;
        end
      end
      if (ack_o) begin ack_n++; ack_pos = post_n; end
    end
    req_i = 1'b0;
    exp_strobe = en ? mx(c1(v.t2), rel) : c1(v.t2);
    exp_post   = v.we ? mx(c1(v.teoc), c1(v.t4)) : c1(v.teoc);
    chk("R3", {tag, " setup cycles (R10 clamp)"}, setup_n, c1(v.t1));
    chk(en ? "R5" : "R4", {tag, " strobe cycles"}, strobe_n, exp_strobe);
    chk("R3", {tag, " wrong-direction strobe cycles"}, wrong_strobe, 0);
    chk("R8", {tag, " busy cycles after strobe"}, post_n, exp_post);
    chk("R7", {tag, " oe cycles after strobe"}, oe_post, v.we ? c1(v.t4) : 0);
    chk("R7", {tag, " bad oe/data cycles"}, oe_bad, 0);
    chk("R6", {tag, " ack count"}, ack_n, 1);
    chk("R6", {tag, " ack position"}, ack_pos, 1);
    chk(poke ? "R9" : "R2", {tag, " select/address errors"}, sel_bad, 0);
    if (!v.we) chk("R6", {tag, " rdata_o"}, rdata_o, v.rd);
    @(negedge clk_i);
    chk(poke ? "R9" : "R8", {tag, " idle after transfer"}, busy_o, 0);
    iordy_i = 1'b0;
  endtask

  initial begin : watchdog
    #(200000 * 5);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin : main
    vec_t v;
    repeat (3) @(negedge clk_i);
    check_idle("R1");
    rst_ni = 1'b1;
    @(negedge clk_i);
    check_idle("R1");

    for (int i = 0; i < NV; i++) begin
      run_req(VECS[i], 1'b0, 0, 1'b0, $sformatf("vec%0d", i));
    end

    // R5: device holds ready low well past T2
    v = VECS[1]; v.we = 1'b0; v.rd = 16'h5AA5;
    run_req(v, 1'b1, 10, 1'b0, "r5_wait");
    // R5: ready already high, no stretch
    v = VECS[0];
    run_req(v, 1'b1, 0, 1'b0, "r5_ready");
    // R9: second request held during busy
    v = VECS[5];
    run_req(v, 1'b0, 0, 1'b1, "r9_poke");
    chk("R9", "rdata_o untouched by ignored read", rdata_o, 16'h5AA5 == 16'h0 ? 0 : int'(VECS[0].rd));

    // R1: asynchronous reset during a strobe
    @(negedge clk_i);
    req_we_i = 1'b1; req_cs1_i = 1'b1; req_addr_i = 3'd4; req_wdata_i = 16'h7777;
    t1_i = 8'd1; t2_i = 8'd20; t4_i = 8'd3; teoc_i = 8'd3; req_iordy_en_i = 1'b0;
    req_i = 1'b1;
    @(negedge clk_i);
    req_i = 1'b0;
    repeat (3) @(negedge clk_i);
    chk("R1", "strobe active before reset", diow_no, 0);
    #1 rst_ni = 1'b0;
    #0.5;
    check_idle("R1");
    @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    check_idle("R1");

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule